// File: doc/BRIEF.md
# Level-Priority Interrupt Arbiter

This block picks, for a single hart, the one interrupt source that should be offered to the core. Each source supplies four things: a pending bit, an enable bit, a 2-bit privilege mode and an 8-bit control byte. Two run-time settings control how the control byte is read. One is the number of control bits that are actually implemented. The other is the number of those bits that form the interrupt level. The remaining implemented bits form the priority. Any bit below the implemented range counts as one.

Sources are ranked by mode first and then by their effective control byte. Because the level sits above the priority inside that byte, this ordering compares level first and priority second. The best-ranked source is then tested against the hart's current privilege. When the source runs at that same privilege, its level is also tested against the larger of two values for that mode: the status level and the programmed threshold. A source that passes is presented as a registered request, together with an identifier word that carries its number, mode and level.

The arbitration is purely combinational across all sources and has a single register stage at the output. The core therefore sees any input change exactly one clock later.

Top module: `irq_level_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `irq_req` is 0 and `irq_id` is all zeros.
- R2: A source is a candidate only when its pending bit and its enable bit are both 1 and its mode is not 2. The mode codes are 0 for user, 1 for supervisor, 3 for machine; code 2 is reserved.
- R3: The effective control byte is the source's byte with its low (8 − `cfg_ctlbits`) bits forced to 1. A `cfg_ctlbits` value above 8 acts as 8.
- R4: A source's level is the top `cfg_nlbits` bits of its effective byte, with every lower bit forced to 1. A `cfg_nlbits` value above 8 acts as 8, and a value of 0 gives a level of 0xFF.
- R5: Among candidates, the one with the larger 10-bit key {mode, effective byte} wins. A higher mode therefore always beats a lower one.
- R6: When two candidates have equal keys, the one with the higher source number wins.
- R7: A winner whose mode is below `cur_priv` is not delivered.
- R8: A winner whose mode equals `cur_priv` is delivered only if its level is strictly greater than the maximum of the status level and the threshold for that mode.
- R9: A winner whose mode is above `cur_priv` is delivered whatever the levels and thresholds are.
- R10: The `irq_id` layout is: source number in bits 11:0, mode in bits 13:12, level in bits 21:14.
- R11: When nothing is delivered, `irq_req` is 0 and `irq_id` is zero.
- R12: Outputs reflect the inputs present at the previous rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_nlbits | input | 4 | Number of level bits in the control byte (0..8) |
| cfg_ctlbits | input | 4 | Number of implemented control bits (0..8) |
| cur_priv | input | 2 | Current privilege mode of the hart |
| stat_lvl_u | input | 8 | Status interrupt level, user mode |
| stat_lvl_s | input | 8 | Status interrupt level, supervisor mode |
| stat_lvl_m | input | 8 | Status interrupt level, machine mode |
| thr_u | input | 8 | Threshold, user mode |
| thr_s | input | 8 | Threshold, supervisor mode |
| thr_m | input | 8 | Threshold, machine mode |
| src_pending | input | NUM_SRC | Pending bit per source |
| src_enable | input | NUM_SRC | Enable bit per source |
| src_mode | input | 2*NUM_SRC | Mode per source; source i uses bits [2i+1:2i] |
| src_ctl | input | 8*NUM_SRC | Control byte per source; source i uses bits [8i+7:8i] |
| irq_req | output | 1 | Registered request to the core |
| irq_id | output | 22 | Registered identifier of the delivered interrupt |

## Verification
The assertions check several properties on every cycle. A delivered mode is never the reserved code and is never below the privilege sampled on the previous edge. A same-mode delivery always carries a level above the previous cycle's effective threshold. No request follows a cycle in which no source was both pending and enabled. An idle output carries a zero identifier. Other behaviour can only be shown by the bench scenarios, which compare against an independent arithmetic model: which source wins, tie-breaking toward higher numbers, the effect of splitting the control byte for every combination of level count and implemented count, and the one-cycle latency.

// File: rtl/irq_arb_pkg.sv
// Package: shared constants, the mode encoding and a helper for forcing
// unimplemented low bits to one.
// Assumes: control bytes are 8 bits wide and modes are 2 bits wide.
package irq_arb_pkg;

    localparam int CTL_W  = 8;
    localparam int MODE_W = 2;
    localparam int KEY_W  = MODE_W + CTL_W;
    localparam int NUM_W  = 12;
    localparam int ID_W   = NUM_W + MODE_W + CTL_W;

    typedef enum logic [MODE_W-1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } prv_e;

    // Returns a mask of (8 - cnt) low ones; any cnt of 8 or more gives zero.
    function automatic logic [CTL_W-1:0] low_ones(input logic [3:0] cnt);
        logic [CTL_W-1:0] m;
        if (cnt >= 4'd8) m = '0;
        else             m = 8'hFF >> cnt;
        return m;
    endfunction

endpackage

// File: rtl/irq_src_decode.sv
// Module: irq_src_decode
// Builds one candidate per source. It produces a valid bit, a ranking key
// {mode, effective byte} and a decoded level.
// Assumes: the configuration counts may exceed 8, and such values are
// treated as 8.
module irq_src_decode
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0]             src_pending,
    input  logic [NUM_SRC-1:0]             src_enable,
    input  logic [MODE_W*NUM_SRC-1:0]      src_mode,
    input  logic [CTL_W*NUM_SRC-1:0]       src_ctl,
    input  logic [3:0]                     cfg_nlbits,
    input  logic [3:0]                     cfg_ctlbits,
    output logic [NUM_SRC-1:0]             cand_vld,
    output logic [NUM_SRC-1:0][KEY_W-1:0]  cand_key,
    output logic [NUM_SRC-1:0][CTL_W-1:0]  cand_lvl
);

    logic [CTL_W-1:0] pad_impl;
    logic [CTL_W-1:0] pad_lvl;

    // Build the two padding masks once; every source shares them.
    always_comb begin
        pad_impl = low_ones(cfg_ctlbits);
        pad_lvl  = low_ones(cfg_nlbits);
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic [MODE_W-1:0] mode_i;
        logic [CTL_W-1:0]  eff_i;

        // Per source: qualify it, form its effective byte, key and level.
        always_comb begin
            mode_i      = src_mode[MODE_W*i +: MODE_W];
            eff_i       = src_ctl[CTL_W*i +: CTL_W] | pad_impl;
            cand_vld[i] = src_pending[i] & src_enable[i] &
                          (mode_i != PRV_RSVD);
            cand_key[i] = {mode_i, eff_i};
            cand_lvl[i] = (eff_i & ~pad_lvl) | pad_lvl;
        end
    end

endmodule

// File: rtl/irq_rank_tree.sv
// Module: irq_rank_tree
// A combinational binary tournament over all candidates. At each node the
// right child wins when its key is greater than or equal to the left
// child's key. Since the right side always holds the higher source numbers,
// ties go to the higher number.
// Assumes: NUM_SRC >= 1. Leaves beyond NUM_SRC are padded as invalid.
module irq_rank_tree
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]             cand_vld,
    input  logic [NUM_SRC-1:0][KEY_W-1:0]  cand_key,
    input  logic [NUM_SRC-1:0][CTL_W-1:0]  cand_lvl,
    output logic                           win_vld,
    output logic [MODE_W-1:0]              win_mode,
    output logic [CTL_W-1:0]               win_lvl,
    output logic [IDX_W-1:0]               win_idx
);

    localparam int DEPTH = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
    localparam int LEAVES = 1 << DEPTH;
    localparam int NODES  = 2 * LEAVES;

    logic             n_vld [1:NODES-1];
    logic [KEY_W-1:0] n_key [1:NODES-1];
    logic [CTL_W-1:0] n_lvl [1:NODES-1];
    logic [IDX_W-1:0] n_idx [1:NODES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_SRC) begin : g_real
            // Leaf fed directly by a source candidate.
            assign n_vld[LEAVES+i] = cand_vld[i];
            assign n_key[LEAVES+i] = cand_key[i];
            assign n_lvl[LEAVES+i] = cand_lvl[i];
            assign n_idx[LEAVES+i] = IDX_W'(i);
        end else begin : g_pad
            // Padding leaf, never valid.
            assign n_vld[LEAVES+i] = 1'b0;
            assign n_key[LEAVES+i] = '0;
            assign n_lvl[LEAVES+i] = '0;
            assign n_idx[LEAVES+i] = '0;
        end
    end

    for (genvar k = 1; k < LEAVES; k++) begin : g_node
        logic take_r;
        // Choose between the two children; equal keys go to the right.
        assign take_r   = n_vld[2*k+1] &&
                          (!n_vld[2*k] || (n_key[2*k+1] >= n_key[2*k]));
        assign n_vld[k] = n_vld[2*k] | n_vld[2*k+1];
        assign n_key[k] = take_r ? n_key[2*k+1] : n_key[2*k];
        assign n_lvl[k] = take_r ? n_lvl[2*k+1] : n_lvl[2*k];
        assign n_idx[k] = take_r ? n_idx[2*k+1] : n_idx[2*k];
    end

    // The root of the tree is the overall winner.
    always_comb begin
        win_vld  = n_vld[1];
        win_mode = n_key[1][KEY_W-1 -: MODE_W];
        win_lvl  = n_lvl[1];
        win_idx  = n_idx[1];
    end

endmodule

// File: rtl/irq_deliver_gate.sv
// Module: irq_deliver_gate
// Tests the winner against the current privilege and the effective
// threshold for that mode, then registers the request and the identifier.
// Assumes: a synchronous, active-low reset, and at most 4096 sources.
module irq_deliver_gate
    import irq_arb_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_vld,
    input  logic [MODE_W-1:0] win_mode,
    input  logic [CTL_W-1:0]  win_lvl,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [MODE_W-1:0] cur_priv,
    input  logic [CTL_W-1:0]  stat_lvl_u,
    input  logic [CTL_W-1:0]  stat_lvl_s,
    input  logic [CTL_W-1:0]  stat_lvl_m,
    input  logic [CTL_W-1:0]  thr_u,
    input  logic [CTL_W-1:0]  thr_s,
    input  logic [CTL_W-1:0]  thr_m,
    output logic              irq_req,
    output logic [ID_W-1:0]   irq_id
);

    logic [CTL_W-1:0] eff_thr;
    logic             deliver;
    logic [NUM_W-1:0] num_ext;

    // Pick the effective threshold for the current privilege mode.
    always_comb begin
        unique case (cur_priv)
            PRV_USER:  eff_thr = (stat_lvl_u > thr_u) ? stat_lvl_u : thr_u;
            PRV_SUPER: eff_thr = (stat_lvl_s > thr_s) ? stat_lvl_s : thr_s;
            PRV_MACH:  eff_thr = (stat_lvl_m > thr_m) ? stat_lvl_m : thr_m;
            default:   eff_thr = '1;
        endcase
    end

    // Decide whether the winner may interrupt the hart right now.
    always_comb begin
        deliver = win_vld &&
                  ((win_mode > cur_priv) ||
                   ((win_mode == cur_priv) && (win_lvl > eff_thr)));
        num_ext = '0;
        num_ext[IDX_W-1:0] = win_idx;
    end

    // Output register: request strobe plus the encoded identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_id  <= '0;
        end else begin
            irq_req <= deliver;
            irq_id  <= deliver ? {win_lvl, win_mode, num_ext} : '0;
        end
    end

    AST_NO_RSVD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_id[13:12] != PRV_RSVD));                        // R2

    AST_NOT_BELOW_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_id[13:12] >= $past(cur_priv)));                 // R7

    AST_LEVEL_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (irq_id[13:12] == $past(cur_priv)))
            |-> (irq_id[21:14] > $past(eff_thr)));                        // R8

    AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_id == '0));                                      // R11

endmodule

// File: rtl/irq_level_arbiter.sv
// Module: irq_level_arbiter (top)
// Interrupt arbiter for one hart. Sources are decoded, ranked in a
// combinational tree, and then gated against privilege and threshold.
// The result goes through a single output register.
// Assumes: 1 <= NUM_SRC <= 4096, and a synchronous, active-low reset.
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [3:0]                  cfg_nlbits,
    input  logic [3:0]                  cfg_ctlbits,
    input  logic [1:0]                  cur_priv,
    input  logic [7:0]                  stat_lvl_u,
    input  logic [7:0]                  stat_lvl_s,
    input  logic [7:0]                  stat_lvl_m,
    input  logic [7:0]                  thr_u,
    input  logic [7:0]                  thr_s,
    input  logic [7:0]                  thr_m,
    input  logic [NUM_SRC-1:0]          src_pending,
    input  logic [NUM_SRC-1:0]          src_enable,
    input  logic [2*NUM_SRC-1:0]        src_mode,
    input  logic [8*NUM_SRC-1:0]        src_ctl,
    output logic                        irq_req,
    output logic [21:0]                 irq_id
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0]            cand_vld;
    logic [NUM_SRC-1:0][KEY_W-1:0] cand_key;
    logic [NUM_SRC-1:0][CTL_W-1:0] cand_lvl;
    logic                          win_vld;
    logic [MODE_W-1:0]             win_mode;
    logic [CTL_W-1:0]              win_lvl;
    logic [IDX_W-1:0]              win_idx;

    irq_src_decode #(.NUM_SRC(NUM_SRC)) u_decode (
        .src_pending (src_pending),
        .src_enable  (src_enable),
        .src_mode    (src_mode),
        .src_ctl     (src_ctl),
        .cfg_nlbits  (cfg_nlbits),
        .cfg_ctlbits (cfg_ctlbits),
        .cand_vld    (cand_vld),
        .cand_key    (cand_key),
        .cand_lvl    (cand_lvl)
    );

    irq_rank_tree #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_tree (
        .cand_vld (cand_vld),
        .cand_key (cand_key),
        .cand_lvl (cand_lvl),
        .win_vld  (win_vld),
        .win_mode (win_mode),
        .win_lvl  (win_lvl),
        .win_idx  (win_idx)
    );

    irq_deliver_gate #(.IDX_W(IDX_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_vld    (win_vld),
        .win_mode   (win_mode),
        .win_lvl    (win_lvl),
        .win_idx    (win_idx),
        .cur_priv   (cur_priv),
        .stat_lvl_u (stat_lvl_u),
        .stat_lvl_s (stat_lvl_s),
        .stat_lvl_m (stat_lvl_m),
        .thr_u      (thr_u),
        .thr_s      (thr_s),
        .thr_m      (thr_m),
        .irq_req    (irq_req),
        .irq_id     (irq_id)
    );

    AST_REQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (~|(src_pending & src_enable)) |=> !irq_req);                    // R2

endmodule

// File: tb/sim_irq_level_arbiter.sv
module sim_irq_level_arbiter;

    localparam int NUM_SRC = 8;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [3:0]                cfg_nl = 4'd8;
    logic [3:0]                cfg_cb = 4'd8;
    logic [1:0]                priv = 2'd0;
    logic [7:0]                su = 0, ss = 0, sm = 0, tu = 0, ts = 0, tm = 0;
    logic [NUM_SRC-1:0]        pend = '0;
    logic [NUM_SRC-1:0]        en = '0;
    logic [NUM_SRC-1:0][1:0]   mode = '0;
    logic [NUM_SRC-1:0][7:0]   ctl = '0;
    logic                      irq_req;
    logic [21:0]               irq_id;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_level_arbiter #(.NUM_SRC(NUM_SRC)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_nlbits(cfg_nl), .cfg_ctlbits(cfg_cb),
        .cur_priv(priv), .stat_lvl_u(su), .stat_lvl_s(ss), .stat_lvl_m(sm),
        .thr_u(tu), .thr_s(ts), .thr_m(tm), .src_pending(pend),
        .src_enable(en), .src_mode(mode), .src_ctl(ctl),
        .irq_req(irq_req), .irq_id(irq_id)
    );

    // Independent arithmetic model: returns {req, id} for the current inputs.
    function automatic logic [22:0] model();
        int nl = (cfg_nl > 8) ? 8 : int'(cfg_nl);
        int cb = (cfg_cb > 8) ? 8 : int'(cfg_cb);
        int best_key = -1;
        int best_i = 0;
        int best_m = 0;
        int best_l = 0;
        int th;
        bit ok;
        for (int i = 0; i < NUM_SRC; i++) begin
            int m = int'(mode[i]);
            int e = int'(ctl[i]) | ((1 << (8 - cb)) - 1);
            int pl = (1 << (8 - nl)) - 1;
            int l = (e & (255 - pl)) | pl;
            int key = m * 256 + e;
            if (pend[i] && en[i] && m != 2 && key >= best_key) begin
                best_key = key; best_i = i; best_m = m; best_l = l;
            end
        end
        case (priv)
            2'd0: th = (su > tu) ? int'(su) : int'(tu);
            2'd1: th = (ss > ts) ? int'(ss) : int'(ts);
            2'd3: th = (sm > tm) ? int'(sm) : int'(tm);
            default: th = 255;
        endcase
        ok = (best_key >= 0) &&
             ((best_m > int'(priv)) || (best_m == int'(priv) && best_l > th));
        if (!ok) return '0;
        return {1'b1, 8'(best_l), 2'(best_m), 12'(best_i)};
    endfunction

    task automatic chk(input string tag, input logic [22:0] got,
                       input logic [22:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got req=%0b id=%06h, expected req=%0b id=%06h",
                     tag, got[22], got[21:0], exp[22], exp[21:0]);
        end
    endtask

    // Capture expected, let one edge pass, then compare at the negedge.
    task automatic step(input string tag);
        logic [22:0] exp = model();
        @(negedge clk);
        chk(tag, {irq_req, irq_id}, exp);
    endtask

    task automatic clear_src();
        pend = '0; en = '0; mode = '0; ctl = '0;
        su = 0; ss = 0; sm = 0; tu = 0; ts = 0; tm = 0;
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state, with inputs trying to raise a request.
        pend = '1; en = '1; mode = '1; ctl = '1;
        repeat (3) @(negedge clk);
        chk("R1 during reset", {irq_req, irq_id}, '0);
        rst_n = 1'b1;
        clear_src();
        step("R1 after reset");

        // R3 R4 R10: sweep every level/implemented count, including values >8.
        for (int nl = 0; nl < 10; nl++) begin
            for (int cb = 0; cb < 10; cb++) begin
                for (int p = 0; p < 2; p++) begin
                    clear_src();
                    cfg_nl = 4'(nl); cfg_cb = 4'(cb); priv = 2'd0;
                    pend[6] = 1'b1; en[6] = 1'b1; mode[6] = 2'd3;
                    ctl[6] = (p == 0) ? 8'h00 : 8'hA5;
                    step("R3 R4 R10 split sweep");
                end
            end
        end

        // R2: pending but disabled, enabled but not pending, reserved mode.
        clear_src(); cfg_nl = 4'd8; cfg_cb = 4'd8;
        pend = '1; step("R2 none enabled");
        chk("R2 none enabled explicit", {irq_req, irq_id}, '0);
        pend = '0; en = '1; step("R2 none pending");
        pend[3] = 1'b1; en = '0; en[3] = 1'b1; mode[3] = 2'd2; ctl[3] = 8'hFF;
        step("R2 R11 reserved mode");
        chk("R2 reserved mode explicit", {irq_req, irq_id}, '0);

        // R5: higher mode beats a larger byte.
        clear_src(); priv = 2'd0;
        pend[1] = 1; en[1] = 1; mode[1] = 2'd1; ctl[1] = 8'hFF;
        pend[2] = 1; en[2] = 1; mode[2] = 2'd3; ctl[2] = 8'h00;
        step("R5 mode dominates");
        chk("R5 winner explicit", {irq_req, irq_id},
            {1'b1, 8'h00, 2'd3, 12'd2});

        // R6: equal keys go to the higher source number.
        clear_src(); priv = 2'd0;
        pend[2] = 1; en[2] = 1; mode[2] = 2'd3; ctl[2] = 8'h60;
        pend[5] = 1; en[5] = 1; mode[5] = 2'd3; ctl[5] = 8'h60;
        step("R6 tie");
        chk("R6 tie explicit", {irq_req, irq_id},
            {1'b1, 8'h60, 2'd3, 12'd5});

        // R7: winner below the current privilege is held back.
        clear_src(); priv = 2'd3;
        pend[0] = 1; en[0] = 1; mode[0] = 2'd1; ctl[0] = 8'hFF;
        step("R7 below priv");
        chk("R7 explicit", {irq_req, irq_id}, '0);

        // R8: equal level is rejected, one above is delivered; threshold wins max.
        clear_src(); priv = 2'd3; sm = 8'h40; tm = 8'h10;
        pend[4] = 1; en[4] = 1; mode[4] = 2'd3; ctl[4] = 8'h40;
        step("R8 equal level");
        chk("R8 equal explicit", {irq_req, irq_id}, '0);
        ctl[4] = 8'h41; step("R8 level above");
        chk("R8 above explicit", {irq_req, irq_id},
            {1'b1, 8'h41, 2'd3, 12'd4});
        sm = 8'h00; tm = 8'h50; ctl[4] = 8'h50; step("R8 threshold larger");
        chk("R8 threshold explicit", {irq_req, irq_id}, '0);

        // R9: higher mode ignores thresholds.
        clear_src(); priv = 2'd1; ss = 8'hFF; ts = 8'hFF; sm = 8'hFF; tm = 8'hFF;
        pend[7] = 1; en[7] = 1; mode[7] = 2'd3; ctl[7] = 8'h00;
        step("R9 higher mode");
        chk("R9 explicit", {irq_req, irq_id}, {1'b1, 8'h00, 2'd3, 12'd7});

        // R12: a change is not visible before the edge, visible after.
        clear_src(); priv = 2'd0; @(negedge clk);
        pend[3] = 1; en[3] = 1; mode[3] = 2'd1; ctl[3] = 8'h80;
        #1 chk("R12 before edge", {irq_req, irq_id}, '0);
        step("R12 after edge");
        chk("R12 after explicit", {irq_req, irq_id},
            {1'b1, 8'h80, 2'd1, 12'd3});

        // R5 R6 R7 R8 R9 R10 R11: pseudo-random sweep over all inputs.
        for (int n = 0; n < 3000; n++) begin
            pend = NUM_SRC'($urandom); en = NUM_SRC'($urandom);
            mode = (2*NUM_SRC)'($urandom);
            for (int i = 0; i < NUM_SRC; i++)
                ctl[i] = ($urandom % 4 == 0) ? 8'h55 : 8'($urandom);
            cfg_nl = 4'($urandom % 10); cfg_cb = 4'($urandom % 10);
            priv = 2'($urandom);
            su = 8'($urandom); ss = 8'($urandom); sm = 8'($urandom);
            tu = 8'($urandom); ts = 8'($urandom); tm = 8'($urandom);
            step("R5 R6 R7 R8 R9 R10 R11 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule